// File: doc/BRIEF.md
# Random Generator Control and Status Interface

This block is the software-facing shell around a random number generator. A 32-bit register bus reaches six word registers: an identity word, a write-only command word, a control word, a status word, an error word and a port that pops the output FIFO. Commands launch a seed operation or a self-test. The sequencer times each operation and reports its result as done flags and error bits. One interrupt line combines those flags under two mask bits.

The entropy path is replaced by a seeded linear-feedback stub. The stub delivers one 32-bit word every `WORD_CYCLES` cycles into a 16-entry FIFO, and only after a seed has succeeded. A test input forces the stub to report a statistical failure. When automatic seeding is enabled, a fresh seed starts without any command once `RESEED_WORDS` words have been popped.

There are two clear commands, and they differ. The interrupt clear only takes effect while no error is latched. The error clear wipes the error word and the done flags together. Software can therefore retry a failed seed without losing track of the fault.

Top module: `rngc_top`

## Requirements
- R1: A read of byte offset 0x00 returns the generator type (parameter, default 2) in bits [31:28], the major revision in bits [15:8] and the minor revision in bits [7:0], with all other bits 0.
- R2: Command word (offset 0x04) bits act only in the cycle they are written. Bit 0 starts a self-test, bit 1 a seed, bit 4 an interrupt clear and bit 5 an error clear. A read of offset 0x04 always returns 0.
- R3: Control word (offset 0x08) bits 4 (auto-seed enable), 5 (done-interrupt mask) and 6 (error-interrupt mask) are writable and read back. Every other bit reads 0. The reset value is 0.
- R4: A seed operation completes SEED_CYCLES cycles after it starts. On success it sets status (offset 0x0C) bit 5, and the FIFO then fills. Status bits [11:8] report the fill level, which reads 15 both at 15 and at 16 entries.
- R5: A self-test completes TEST_CYCLES cycles after it starts and sets status bit 4. If the stub reports a failure at completion, error word (offset 0x10) bit 1 is also set.
- R6: A seed that completes with the stub failing sets status bit 5 and error bit 3, and leaves the FIFO empty. A new seed command restarts the operation from the beginning, and it then succeeds with the error word at 0.
- R7: Each read of offset 0x14 with a non-empty FIFO returns the oldest word and lowers the level by one. Successive words are nonzero and differ from one another.
- R8: A read of offset 0x14 with an empty FIFO returns 0 and sets error bit 0.
- R9: Status bit 16 is set whenever any error bit is set. The interrupt is high exactly when (a done flag is set and bit 5 of the control word is 0) or (status bit 16 is set and bit 6 of the control word is 0).
- R10: An interrupt clear (command bit 4) clears both done flags only while the error word is 0. Otherwise it changes nothing.
- R11: An error clear (command bit 5) clears the error word and both done flags.
- R12: With control bit 4 set, a seed starts by itself once RESEED_WORDS words have been popped since the last seed started. That seed flushes the FIFO and sets status bit 5 when done. With bit 4 clear, no seed starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on bus_rdata after the next edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| stub_fail | input | 1 | Forces the stub to report a statistical failure when an operation completes |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume one bus access per cycle: `bus_wr` and `bus_rd` are never high together. The clear properties hold only when no operation finishes in the same cycle, because a finishing operation's result takes priority over a clear. The bench drives each access as a single strobe cycle followed by an idle cycle, and it issues clear commands only once polling has shown that the operation in flight is finished. `stub_fail` changes only while no operation is running, so each result is decided by one stable value.

// File: rtl/rngc_pkg.sv
package rngc_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    // register byte offsets
    localparam logic [ADDR_W-1:0] OFF_VER  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_CMD  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_STAT = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_ERR  = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_FIFO = 8'h14;

    // command bits
    localparam int CMD_TEST   = 0;
    localparam int CMD_SEED   = 1;
    localparam int CMD_CLRINT = 4;
    localparam int CMD_CLRERR = 5;

    // error bits
    localparam int ERR_UNDER = 0;
    localparam int ERR_TEST  = 1;
    localparam int ERR_STAT  = 3;

    typedef enum logic [1:0] {OP_IDLE, OP_SEED, OP_TEST} op_e;
endpackage

// File: rtl/rngc_stub.sv
module rngc_stub #(
    parameter int W      = 32,
    parameter int PERIOD = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         run,
    output logic         valid,
    output logic [W-1:0] word
);
    localparam int PW = $clog2(PERIOD + 1);
    localparam logic [W-1:0] TAPS = W'(32'h80200003);

    typedef struct packed {
        logic [W-1:0]  lfsr;
        logic [PW-1:0] tmr;
        logic [15:0]   mix;
    } stub_t;

    stub_t q, d;
    logic [W-1:0] seed_v;

    assign valid  = run && (q.tmr == PW'(PERIOD - 1));
    assign word   = q.lfsr;
    assign seed_v = q.lfsr ^ W'({q.mix, ~q.mix});

    always_comb begin
        d     = q;
        d.mix = q.mix + 16'd1;
        if (load) begin
            d.lfsr = (seed_v == '0) ? W'(1) : seed_v;
            d.tmr  = '0;
        end else if (!run) begin
            d.tmr = '0;
        end else if (valid) begin
            d.lfsr = (q.lfsr >> 1) ^ (q.lfsr[0] ? TAPS : '0);
            d.tmr  = '0;
        end else begin
            d.tmr = q.tmr + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.lfsr <= W'(32'h6A09E667);
            q.tmr  <= '0;
            q.mix  <= '0;
        end else begin
            q <= d;
        end
    end

    // R7
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word != '0);
endmodule

// File: rtl/rngc_fifo.sv
module rngc_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t q, d;
    logic [W-1:0] mem_q [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign dout  = mem_q[q.rd];
    assign count = q.cnt;

    always_comb begin
        d = q;
        if (flush) begin
            d = '0;
        end else begin
            if (push) d.wr = bump(q.wr);
            if (pop)  d.rd = bump(q.rd);
            d.cnt = q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem_q[q.wr] <= din;
    end

    // R4
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && !pop && q.cnt == CW'(DEPTH)));
    // R8
    fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && q.cnt == '0));
endmodule

// File: rtl/rngc_seq.sv
module rngc_seq
    import rngc_pkg::*;
#(
    parameter int SEED_CYCLES  = 16,
    parameter int TEST_CYCLES  = 12,
    parameter int RESEED_WORDS = 1 << 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic seed_cmd,
    input  logic test_cmd,
    input  logic auto_en,
    input  logic word_served,
    input  logic stub_fail,
    output logic seed_go,
    output logic busy,
    output logic seeded,
    output logic seed_ok,
    output logic seed_fail,
    output logic test_ok,
    output logic test_fail
);
    localparam int LONGEST = (SEED_CYCLES > TEST_CYCLES) ? SEED_CYCLES : TEST_CYCLES;
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam int SRV_W   = $clog2(RESEED_WORDS + 1);

    typedef struct packed {
        op_e              op;
        logic [CNT_W-1:0] cnt;
        logic [SRV_W-1:0] served;
        logic             seeded;
    } seq_t;

    seq_t q, d;
    logic last, fin, auto_hit;

    assign last = (q.op == OP_SEED) ? (q.cnt == CNT_W'(SEED_CYCLES - 1))
                                    : (q.cnt == CNT_W'(TEST_CYCLES - 1));
    assign fin      = (q.op != OP_IDLE) && last;
    assign auto_hit = auto_en && (q.served == SRV_W'(RESEED_WORDS)) && (q.op == OP_IDLE);
    assign seed_go  = seed_cmd || auto_hit;

    assign seed_ok   = fin && !seed_go && (q.op == OP_SEED) && !stub_fail;
    assign seed_fail = fin && !seed_go && (q.op == OP_SEED) &&  stub_fail;
    assign test_ok   = fin && !seed_go && (q.op == OP_TEST) && !stub_fail;
    assign test_fail = fin && !seed_go && (q.op == OP_TEST) &&  stub_fail;
    assign busy      = (q.op != OP_IDLE);
    assign seeded    = q.seeded;

    always_comb begin
        d = q;
        if (seed_go) begin
            d.op     = OP_SEED;
            d.cnt    = '0;
            d.served = '0;
            d.seeded = 1'b0;
        end else begin
            if (word_served && q.served != SRV_W'(RESEED_WORDS))
                d.served = q.served + SRV_W'(1);
            if (q.op == OP_IDLE) begin
                if (test_cmd) begin
                    d.op  = OP_TEST;
                    d.cnt = '0;
                end
            end else if (last) begin
                d.op = OP_IDLE;
                if (q.op == OP_SEED && !stub_fail) d.seeded = 1'b1;
            end else begin
                d.cnt = q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.op     <= OP_IDLE;
            q.cnt    <= '0;
            q.served <= '0;
            q.seeded <= 1'b0;
        end else begin
            q <= d;
        end
    end

    // R5
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({seed_ok, seed_fail, test_ok, test_fail}));
    // R6
    seed_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_cmd |=> (q.op == OP_SEED && q.cnt == '0 && !q.seeded));
    // R12
    auto_reseed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && q.served == SRV_W'(RESEED_WORDS) && q.op == OP_IDLE) |=> (q.op == OP_SEED));
    // R4
    seeded_after_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.seeded) |-> $past(seed_ok));
endmodule

// File: rtl/rngc_top.sv
module rngc_top
    import rngc_pkg::*;
#(
    parameter int GEN_TYPE     = 2,
    parameter int REV_MAJ      = 3,
    parameter int REV_MIN      = 5,
    parameter int FIFO_DEPTH   = 16,
    parameter int WORD_CYCLES  = 4,
    parameter int SEED_CYCLES  = 16,
    parameter int TEST_CYCLES  = 12,
    parameter int RESEED_WORDS = 1 << 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              stub_fail,
    output logic              irq
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);
    localparam logic [DATA_W-1:0] VER_WORD =
        {4'(GEN_TYPE), 12'h000, 8'(REV_MAJ), 8'(REV_MIN)};

    typedef struct packed {
        logic [2:0]        ctrl;      // [0] auto, [1] mask done, [2] mask err
        logic              st_done;
        logic              seed_done;
        logic [3:0]        err;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t q, d;

    logic wr_cmd, wr_ctrl, rd_fifo;
    logic seed_cmd, test_cmd, clr_int, clr_err;
    logic pop, underflow, any_evt;
    logic seed_go, busy, seeded, seed_ok, seed_fail, test_ok, test_fail;
    logic stub_valid, stub_run;
    logic [DATA_W-1:0] stub_word, fifo_dout;
    logic [CW-1:0] fifo_cnt;
    logic [3:0] level;
    logic [DATA_W-1:0] stat_word;
    logic unused_wbits;

    assign wr_cmd    = bus_wr && (bus_addr == OFF_CMD);
    assign wr_ctrl   = bus_wr && (bus_addr == OFF_CTRL);
    assign rd_fifo   = bus_rd && (bus_addr == OFF_FIFO);
    assign seed_cmd  = wr_cmd && bus_wdata[CMD_SEED];
    assign test_cmd  = wr_cmd && bus_wdata[CMD_TEST];
    assign clr_int   = wr_cmd && bus_wdata[CMD_CLRINT];
    assign clr_err   = wr_cmd && bus_wdata[CMD_CLRERR];
    assign pop       = rd_fifo && (fifo_cnt != '0);
    assign underflow = rd_fifo && (fifo_cnt == '0);
    assign any_evt   = seed_ok | seed_fail | test_ok | test_fail;
    assign stub_run  = seeded && !busy && (fifo_cnt < CW'(FIFO_DEPTH));
    assign level     = (fifo_cnt > CW'(15)) ? 4'hF : 4'(fifo_cnt);
    assign stat_word = {15'h0, (q.err != '0), 4'h0, level, 2'b00, q.seed_done, q.st_done, 4'h0};
    assign unused_wbits = ^{bus_wdata[31:7], bus_wdata[3:2]};

    rngc_seq #(
        .SEED_CYCLES (SEED_CYCLES),
        .TEST_CYCLES (TEST_CYCLES),
        .RESEED_WORDS(RESEED_WORDS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .seed_cmd   (seed_cmd),
        .test_cmd   (test_cmd),
        .auto_en    (q.ctrl[0]),
        .word_served(pop),
        .stub_fail  (stub_fail),
        .seed_go    (seed_go),
        .busy       (busy),
        .seeded     (seeded),
        .seed_ok    (seed_ok),
        .seed_fail  (seed_fail),
        .test_ok    (test_ok),
        .test_fail  (test_fail)
    );

    rngc_stub #(.W(DATA_W), .PERIOD(WORD_CYCLES)) u_stub (
        .clk  (clk),
        .rst_n(rst_n),
        .load (seed_go),
        .run  (stub_run),
        .valid(stub_valid),
        .word (stub_word)
    );

    rngc_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .flush(seed_go),
        .push (stub_valid),
        .din  (stub_word),
        .pop  (pop),
        .dout (fifo_dout),
        .count(fifo_cnt)
    );

    always_comb begin
        d = q;
        // clears first, so that same-cycle results still land
        if (clr_err) begin
            d.err       = '0;
            d.st_done   = 1'b0;
            d.seed_done = 1'b0;
        end else if (clr_int && q.err == '0) begin
            d.st_done   = 1'b0;
            d.seed_done = 1'b0;
        end
        if (test_ok || test_fail) d.st_done   = 1'b1;
        if (seed_ok || seed_fail) d.seed_done = 1'b1;
        if (test_fail)            d.err[ERR_TEST]  = 1'b1;
        if (seed_fail)            d.err[ERR_STAT]  = 1'b1;
        if (underflow)            d.err[ERR_UNDER] = 1'b1;

        if (wr_ctrl) d.ctrl = bus_wdata[6:4];

        if (bus_rd) begin
            case (bus_addr)
                OFF_VER:  d.rdata = VER_WORD;
                OFF_CTRL: d.rdata = {25'h0, q.ctrl, 4'h0};
                OFF_STAT: d.rdata = stat_word;
                OFF_ERR:  d.rdata = {28'h0, q.err};
                OFF_FIFO: d.rdata = pop ? fifo_dout : '0;
                default:  d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_rdata = q.rdata;
    assign irq = ((q.st_done | q.seed_done) & ~q.ctrl[1]) | ((q.err != '0) & ~q.ctrl[2]);

    // R2
    cmd_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFF_CMD) |=> (bus_rdata == '0));
    // R8
    underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> (bus_rdata == '0 && q.err[ERR_UNDER]));
    // R10
    clr_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_int && !clr_err && q.err == '0 && !any_evt) |=> (!q.st_done && !q.seed_done));
    // R10
    clr_int_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_int && !clr_err && q.err != '0) |=>
            (($past(q.st_done) -> q.st_done) && ($past(q.seed_done) -> q.seed_done)));
    // R11
    clr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err && !any_evt) |=> (q.err == '0 && !q.st_done && !q.seed_done));
endmodule

// File: tb/test_rngc_top.sv
module test_rngc_top;
    localparam int RESEED  = 20;
    localparam int WORDCYC = 32;
    localparam logic [7:0] A_VER = 8'h00, A_CMD = 8'h04, A_CTRL = 8'h08,
                           A_STAT = 8'h0C, A_ERR = 8'h10, A_FIFO = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        stub_fail = 1'b0;
    logic        irq;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    rngc_top #(
        .WORD_CYCLES (WORDCYC),
        .SEED_CYCLES (16),
        .TEST_CYCLES (12),
        .RESEED_WORDS(RESEED)
    ) i_rngc_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stub_fail(stub_fail), .irq(irq)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic poll_bit(input int b, output logic [31:0] st);
        for (int i = 0; i < 200; i++) begin
            rd(A_STAT, st);
            if (st[b]) break;
        end
    endtask

    task automatic poll_level(input logic [3:0] want, output logic [31:0] st);
        for (int i = 0; i < 1000; i++) begin
            rd(A_STAT, st);
            if (st[11:8] >= want) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_VER, v);  check("R1", "version word", v, 32'h2000_0305);
        rd(A_CMD, v);  check("R2", "command reads zero", v, 0);
        rd(A_CTRL, v); check("R3", "control reset", v, 0);
        rd(A_STAT, v); check("R9", "status reset", v, 0);
        rd(A_ERR, v);  check("R9", "error reset", v, 0);
        check("R9", "irq reset", irq, 0);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        wr(A_CTRL, 32'h70); rd(A_CTRL, v); check("R3", "control readback", v, 32'h70);
        wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, v); check("R3", "control other bits", v, 32'h70);
        check("R9", "irq with no flags", irq, 0);
        wr(A_CTRL, 0);
    endtask

    task automatic t_underflow();
        logic [31:0] v;
        rd(A_FIFO, v); check("R8", "empty read data", v, 0);
        rd(A_ERR, v);  check("R8", "underflow bit", v, 32'h1);
        rd(A_STAT, v); check("R9", "status error bit", v, 32'h1_0000);
        check("R9", "irq on error", irq, 1);
        wr(A_CTRL, 32'h40); check("R9", "error masked", irq, 0);
        wr(A_CTRL, 0);
        wr(A_CMD, 32'h10); rd(A_ERR, v); check("R10", "int clear keeps error", v, 32'h1);
        wr(A_CMD, 32'h20); rd(A_ERR, v); check("R11", "error cleared", v, 0);
        rd(A_STAT, v); check("R11", "status after clear", v, 0);
        check("R9", "irq after clear", irq, 0);
    endtask

    task automatic t_selftest();
        logic [31:0] v;
        wr(A_CMD, 32'h1);
        rd(A_CMD, v); check("R2", "command self-clears", v, 0);
        poll_bit(4, v);
        check("R5", "self-test done", v & 32'h1_0030, 32'h10);
        check("R9", "irq on done", irq, 1);
        wr(A_CTRL, 32'h20); check("R9", "done masked", irq, 0);
        wr(A_CTRL, 0); check("R9", "done unmasked", irq, 1);
        wr(A_CMD, 32'h10);
        rd(A_STAT, v); check("R10", "int clear clears done", v, 0);
        check("R10", "irq after int clear", irq, 0);
    endtask

    task automatic t_selftest_fail();
        logic [31:0] v;
        stub_fail = 1'b1;
        wr(A_CMD, 32'h1);
        poll_bit(4, v);
        rd(A_ERR, v);  check("R5", "self-test failure bit", v, 32'h2);
        rd(A_STAT, v); check("R9", "status on failed test", v & 32'h1_0010, 32'h1_0010);
        wr(A_CMD, 32'h10);
        rd(A_STAT, v); check("R10", "int clear blocked by error", v & 32'h10, 32'h10);
        wr(A_CMD, 32'h20);
        rd(A_STAT, v); check("R11", "status after error clear", v, 0);
        rd(A_ERR, v);  check("R11", "error word after clear", v, 0);
        stub_fail = 1'b0;
    endtask

    task automatic t_seed();
        logic [31:0] v;
        stub_fail = 1'b1;
        wr(A_CMD, 32'h2);
        poll_bit(5, v);
        rd(A_ERR, v); check("R6", "statistical failure bit", v, 32'h8);
        repeat (100) @(negedge clk);
        rd(A_STAT, v); check("R6", "fifo empty after failed seed", v[11:8], 0);
        stub_fail = 1'b0;
        wr(A_CMD, 32'h20);
        wr(A_CMD, 32'h2);
        repeat (5) @(negedge clk);
        wr(A_CMD, 32'h2);
        poll_bit(5, v);
        check("R6", "retry seed done", v[5], 1);
        rd(A_ERR, v); check("R6", "retry error word", v, 0);
        poll_level(4'hF, v);
        check("R4", "fifo level full", v[11:8], 15);
        repeat (100) @(negedge clk);
        rd(A_STAT, v); check("R4", "level saturates", v[11:8], 15);
    endtask

    task automatic t_pop();
        logic [31:0] a, b, c, v;
        rd(A_FIFO, a); rd(A_FIFO, b); rd(A_FIFO, c);
        rd(A_STAT, v); check("R7", "level after three pops", v[11:8], 13);
        check("R7", "first word nonzero", (a != 0), 1);
        check("R7", "words differ 1-2", (a != b), 1);
        check("R7", "words differ 2-3", (b != c), 1);
    endtask

    task automatic read_words(input int n);
        logic [31:0] v;
        for (int i = 0; i < n; i++) begin
            poll_level(4'h1, v);
            rd(A_FIFO, v);
        end
    endtask

    task automatic t_auto();
        logic [31:0] v;
        wr(A_CMD, 32'h10);
        wr(A_CTRL, 0);
        wr(A_CMD, 32'h2);
        poll_bit(5, v);
        wr(A_CMD, 32'h10);
        read_words(RESEED);
        repeat (80) @(negedge clk);
        rd(A_STAT, v); check("R12", "no reseed when disabled", v[5], 0);
        wr(A_CMD, 32'h2);
        poll_bit(5, v);
        wr(A_CMD, 32'h10);
        wr(A_CTRL, 32'h10);
        read_words(RESEED);
        poll_bit(5, v);
        check("R12", "automatic reseed done", v[5], 1);
        rd(A_ERR, v); check("R12", "no error during reads", v, 0);
        wr(A_CTRL, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl();
        t_underflow();
        t_selftest();
        t_selftest_fail();
        t_seed();
        t_pop();
        t_auto();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        total++;
        bad++;
        $display("FAIL all watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule